// File: doc/BRIEF.md
# Hybrid Branch Target and History Predictor

This block sits beside instruction fetch and guesses where fetch goes next. Every cycle in which fetch presents an address for an aligned pair of 4-byte instructions, the block answers one cycle later with a next address, a taken flag and a code naming the structure that produced the answer. It uses three structures, consulted in priority order. A return hint from predecode takes its target from a small return address stack. Otherwise, a hit in a two-way set-associative target buffer redirects fetch to the stored target. Otherwise, a table of 2-bit counters, indexed by the address folded with a global outcome history, supplies only a direction. Fetch then continues at the pair address plus 8, and the taken flag tells decode to compute the target itself.

Execute returns each resolved branch on an update port. The update carries the outcome, the target, the history value that was reported with that branch's prediction, and a misprediction flag. Updates train the counters, allocate or drop target buffer entries and shift the history. On a misprediction, the history is rebuilt from the returned checkpoint. A two-state machine then raises a one-cycle pipeline flush with the corrected fetch address. Its states are ST_RUN and ST_FLUSH. MISS takes ST_RUN to ST_FLUSH, HOLD keeps ST_RUN, REFLUSH keeps ST_FLUSH when another misprediction arrives during the flush, and RESUME returns ST_FLUSH to ST_RUN.

Top module: `fetch_predictor`

## Requirements
- R1: After reset, pred_valid and flush are low. All target buffer entries are invalid, every history counter holds 01 (weakly not taken), the history register is zero and the return stack is empty.
- R2: A prediction appears on the clock edge after the fetch request is sampled, and pred_valid equals fetch_valid one cycle delayed.
- R3: Target buffer lookup uses set = fetch_pc[10:3] and tag = fetch_pc[31:11]. On a hit with no return hint, pred_pc is the stored target, pred_taken is 1 and pred_src is 01.
- R4: On a target buffer miss with no return hint, pred_src is 00 and pred_pc is fetch_pc + 8. pred_taken is 1 exactly when the counter at index fetch_pc[13:2] XOR history is 2 or 3.
- R5: Every update moves the counter at index upd_pc[13:2] XOR upd_hist up on taken and down on not taken, saturating at 3 and 0.
- R6: A resolved taken branch that misses the target buffer is written into an invalid way of its set, or else into the way that the set's LRU bit names. Any write points the LRU bit at the other way. A taken update that hits rewrites the target.
- R7: A resolved not-taken branch that hits the target buffer invalidates that entry.
- R8: Each update without misprediction shifts the outcome into bit 0 of the history register. pred_hist reports the history value used for each prediction.
- R9: A mispredicted update sets the history register to {upd_hist[10:0], upd_taken}.
- R10: A mispredicted update raises flush for exactly the next cycle, with redirect_pc equal to upd_target if taken, or else upd_pc + 4. Updates without misprediction leave flush low.
- R11: A return hint (hint_ret) gives pred_pc = top of the return stack, pred_taken = 1 and pred_src = 10, ahead of any target buffer hit.
- R12: A call hint (hint_call without hint_ret) pushes fetch_pc + 4 onto the 8-entry stack. Pushing onto a full stack overwrites the oldest entry.
- R13: A pop when at most one entry is held returns the current top without moving the stack pointer and leaves the stack empty, so repeated underflow returns the same last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address present this cycle |
| fetch_pc | input | 32 | Address of the fetched 8-byte pair |
| hint_call | input | 1 | Predecode marks the pair as containing a call |
| hint_ret | input | 1 | Predecode marks the pair as containing a return |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved taken target |
| upd_mispredict | input | 1 | Prediction for this branch was wrong |
| upd_hist | input | 12 | History value reported with the branch's prediction |
| pred_valid | output | 1 | Prediction valid |
| pred_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Predicted direction |
| pred_src | output | 2 | 00 history table, 01 target buffer, 10 return stack |
| pred_hist | output | 12 | History value used for this prediction |
| flush | output | 1 | Flush the pipeline |
| redirect_pc | output | 32 | Corrected fetch address while flush is high |

## Verification
A fetch request driven between edges is captured on the next rising edge, and its prediction is read at the falling edge after that. The monitor pops one expected item from the scoreboard for each cycle in which pred_valid is high, so order alone ties every answer to its request. An update driven before an edge changes the tables, history and stack at that edge, so a fetch driven one half-cycle later already sees the new state. The expected values come from a counter and history model in the bench that follows R5, R8 and R9. Flush and redirect_pc are checked one cycle after the mispredicted update, and flush is checked low again one cycle later.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        SRC_HIST = 2'b00,
        SRC_BTB  = 2'b01,
        SRC_RAS  = 2'b10
    } pred_src_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } redir_state_e;
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
    parameter int PC_W = 32,
    parameter int SETS = 256,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = PC_W - 3 - SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PC_W-1:0]  lk_tgt,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [SET_W-1:0] upd_set,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [PC_W-1:0]  upd_target
);
    localparam int WAYS = 2;

    logic [WAYS-1:0]  vld_q [SETS];
    logic             lru_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PC_W-1:0]  tgt_q [SETS][WAYS];

    logic [WAYS-1:0] l_hit_w;
    logic [WAYS-1:0] u_hit_w;
    logic            u_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign l_hit_w[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign u_hit_w[w] = vld_q[upd_set][w] && (tag_q[upd_set][w] == upd_tag);
    end

    assign lk_hit = |l_hit_w;
    assign lk_tgt = l_hit_w[1] ? tgt_q[lk_set][1] : tgt_q[lk_set][0];

    // way chosen for a write: the hitting way, else a free way, else LRU
    always_comb begin
        if (|u_hit_w)                 u_way = u_hit_w[1];
        else if (!vld_q[upd_set][0])  u_way = 1'b0;
        else if (!vld_q[upd_set][1])  u_way = 1'b1;
        else                          u_way = lru_q[upd_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
        end else if (upd_valid) begin
            if (upd_taken) begin
                vld_q[upd_set][u_way] <= 1'b1;
                lru_q[upd_set]        <= ~u_way;
            end else if (|u_hit_w) begin
                vld_q[upd_set][u_way] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid && upd_taken) begin
            tag_q[upd_set][u_way] <= upd_tag;
            tgt_q[upd_set][u_way] <= upd_target;
        end
    end
endmodule

// File: rtl/bp_ght.sv
module bp_ght #(
    parameter int ENTRIES = 4096,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_bits,
    output logic             lk_taken,
    output logic [IDX_W-1:0] ghr,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic             upd_mispredict,
    input  logic [IDX_W-1:0] upd_bits,
    input  logic [IDX_W-1:0] upd_hist
);
    logic [1:0]       cnt_q [ENTRIES];
    logic [IDX_W-1:0] ghr_q;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [1:0]       up_cur;

    assign lk_idx   = lk_bits ^ ghr_q;
    assign up_idx   = upd_bits ^ upd_hist;
    assign up_cur   = cnt_q[up_idx];
    assign lk_taken = cnt_q[lk_idx][1];
    assign ghr      = ghr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= 2'b01;
        end else if (upd_valid) begin
            if (upd_taken && up_cur != 2'b11)
                cnt_q[up_idx] <= up_cur + 2'b01;
            else if (!upd_taken && up_cur != 2'b00)
                cnt_q[up_idx] <= up_cur - 2'b01;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ghr_q <= '0;
        else if (upd_valid && upd_mispredict)
            ghr_q <= {upd_hist[IDX_W-2:0], upd_taken};
        else if (upd_valid)
            ghr_q <= {ghr_q[IDX_W-2:0], upd_taken};
    end
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_val,
    input  logic            pop,
    output logic [PC_W-1:0] top
);
    logic [PC_W-1:0]  stk_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;
    logic [CNT_W-1:0] cnt_q;

    assign ptr_up = ptr_q + PTR_W'(1);
    assign ptr_dn = ptr_q - PTR_W'(1);
    assign top    = stk_q[ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (pop) begin
            if (cnt_q > CNT_W'(1)) begin
                ptr_q <= ptr_dn;
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                cnt_q <= '0;
            end
        end else if (push) begin
            ptr_q         <= ptr_up;
            stk_q[ptr_up] <= push_val;
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bp_redirect.sv
module bp_redirect
    import bp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic            upd_mispredict,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);
    redir_state_e    state_q, state_d;
    logic [PC_W-1:0] fix_q;
    logic            miss;

    assign miss = upd_valid && upd_mispredict;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fix_q <= '0;
        else if (miss)
            fix_q <= upd_taken ? upd_target : upd_pc + PC_W'(4);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = miss ? ST_FLUSH : ST_RUN;    // MISS / HOLD
            ST_FLUSH: state_d = miss ? ST_FLUSH : ST_RUN;    // REFLUSH / RESUME
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        flush       = 1'b0;
        redirect_pc = fix_q;
        unique case (state_q)
            ST_RUN:   flush = 1'b0;
            ST_FLUSH: flush = 1'b1;
            default:  flush = 1'b0;
        endcase
    end
endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int BTB_SETS    = 256,
    parameter int GHT_ENTRIES = 4096,
    parameter int RAS_DEPTH   = 8,
    localparam int HIST_W = $clog2(GHT_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              hint_call,
    input  logic              hint_ret,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [PC_W-1:0]   upd_target,
    input  logic              upd_mispredict,
    input  logic [HIST_W-1:0] upd_hist,
    output logic              pred_valid,
    output logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [1:0]        pred_src,
    output logic [HIST_W-1:0] pred_hist,
    output logic              flush,
    output logic [PC_W-1:0]   redirect_pc
);
    localparam int SET_W = $clog2(BTB_SETS);
    localparam int TAG_W = PC_W - 3 - SET_W;

    logic              btb_hit;
    logic [PC_W-1:0]   btb_tgt;
    logic              ght_taken;
    logic [HIST_W-1:0] ghr;
    logic [PC_W-1:0]   ras_top;
    logic              ras_pop;
    logic              ras_push;

    logic [PC_W-1:0]   nx_pc;
    logic              nx_taken;
    pred_src_e         nx_src;

    assign ras_pop  = fetch_valid && hint_ret;
    assign ras_push = fetch_valid && hint_call && !hint_ret;

    bp_btb #(.PC_W(PC_W), .SETS(BTB_SETS)) u_btb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (fetch_pc[3 +: SET_W]),
        .lk_tag     (fetch_pc[PC_W-1 -: TAG_W]),
        .lk_hit     (btb_hit),
        .lk_tgt     (btb_tgt),
        .upd_valid  (upd_valid),
        .upd_taken  (upd_taken),
        .upd_set    (upd_pc[3 +: SET_W]),
        .upd_tag    (upd_pc[PC_W-1 -: TAG_W]),
        .upd_target (upd_target)
    );

    bp_ght #(.ENTRIES(GHT_ENTRIES)) u_ght (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_bits        (fetch_pc[2 +: HIST_W]),
        .lk_taken       (ght_taken),
        .ghr            (ghr),
        .upd_valid      (upd_valid),
        .upd_taken      (upd_taken),
        .upd_mispredict (upd_mispredict),
        .upd_bits       (upd_pc[2 +: HIST_W]),
        .upd_hist       (upd_hist)
    );

    bp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ras_push),
        .push_val (fetch_pc + PC_W'(4)),
        .pop      (ras_pop),
        .top      (ras_top)
    );

    bp_redirect #(.PC_W(PC_W)) u_redir (
        .clk            (clk),
        .rst_n          (rst_n),
        .upd_valid      (upd_valid),
        .upd_mispredict (upd_mispredict),
        .upd_taken      (upd_taken),
        .upd_pc         (upd_pc),
        .upd_target     (upd_target),
        .flush          (flush),
        .redirect_pc    (redirect_pc)
    );

    // source priority: return stack, then target buffer, then history table
    always_comb begin
        if (hint_ret) begin
            nx_src   = SRC_RAS;
            nx_pc    = ras_top;
            nx_taken = 1'b1;
        end else if (btb_hit) begin
            nx_src   = SRC_BTB;
            nx_pc    = btb_tgt;
            nx_taken = 1'b1;
        end else begin
            nx_src   = SRC_HIST;
            nx_pc    = fetch_pc + PC_W'(8);
            nx_taken = ght_taken;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_pc    <= '0;
            pred_taken <= 1'b0;
            pred_src   <= SRC_HIST;
            pred_hist  <= '0;
        end else begin
            pred_valid <= fetch_valid;
            pred_pc    <= nx_pc;
            pred_taken <= nx_taken;
            pred_src   <= nx_src;
            pred_hist  <= ghr;
        end
    end
endmodule

// File: rtl/fetch_predictor_chk.sv
module fetch_predictor_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              hint_call,
    input logic              hint_ret,
    input logic              upd_valid,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [PC_W-1:0]   upd_target,
    input logic              upd_mispredict,
    input logic [HIST_W-1:0] upd_hist,
    input logic              pred_valid,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic [1:0]        pred_src,
    input logic [HIST_W-1:0] pred_hist,
    input logic              flush,
    input logic [PC_W-1:0]   redirect_pc
);
    // R2
    pred_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid);
    // R2
    pred_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !pred_valid);
    // R4
    hist_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> (pred_src != 2'b00) || (pred_pc == $past(fetch_pc) + PC_W'(8)));
    // R11
    ret_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && hint_ret |=> pred_taken && (pred_src == 2'b10));
    // R10
    flush_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_mispredict |=> flush);
    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && upd_mispredict) |=> !flush);
    // R10
    redirect_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_mispredict && upd_taken |=> redirect_pc == $past(upd_target));
endmodule

bind fetch_predictor fetch_predictor_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/sim_fetch_predictor.sv
`timescale 1ns/1ps
module sim_fetch_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        hint_call = 1'b0;
    logic        hint_ret = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispredict = 1'b0;
    logic [11:0] upd_hist = '0;
    logic        pred_valid;
    logic [31:0] pred_pc;
    logic        pred_taken;
    logic [1:0]  pred_src;
    logic [11:0] pred_hist;
    logic        flush;
    logic [31:0] redirect_pc;

    always #4 clk = ~clk;

    fetch_predictor u0 (.*);

    typedef struct {
        logic [31:0] pc;
        logic        taken;
        logic [1:0]  src;
        logic [11:0] hist;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          nvec = 0;
    int          nbad = 0;
    bit          done = 1'b0;
    int          m_cnt [4096];
    logic [11:0] m_ghr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int midx(input logic [31:0] pc, input logic [11:0] h);
        return int'(pc[13:2] ^ h);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pred_valid && !done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected prediction", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(pred_pc == e.pc, e.req, "pred_pc", pred_pc, e.pc);
                chk(pred_taken == e.taken, e.req, "pred_taken", 32'(pred_taken), 32'(e.taken));
                chk(pred_src == e.src, e.req, "pred_src", 32'(pred_src), 32'(e.src));
                chk(pred_hist == e.hist, "R8", "pred_hist", 32'(pred_hist), 32'(e.hist));
            end
        end
    end

    // src: 0 history table, 1 target buffer, 2 return stack
    task automatic fetch(input logic [31:0] pc, input bit call, input bit ret,
                         input logic [1:0] src, input logic [31:0] tgt, input string req);
        exp_t e;
        @(negedge clk);
        fetch_pc = pc; hint_call = call; hint_ret = ret; fetch_valid = 1'b1;
        e.src = src; e.hist = m_ghr; e.req = req;
        if (src == 2'd0) begin
            e.pc = pc + 32'd8;
            e.taken = (m_cnt[midx(pc, m_ghr)] >= 2);
        end else begin
            e.pc = tgt;
            e.taken = 1'b1;
        end
        sb.push_back(e);
        @(negedge clk);
        fetch_valid = 1'b0; hint_call = 1'b0; hint_ret = 1'b0;
    endtask

    task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                          input bit mis, input logic [11:0] h);
        int i;
        @(negedge clk);
        upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_mispredict = mis;
        upd_hist = h; upd_valid = 1'b1;
        i = midx(pc, h);
        if (tk && m_cnt[i] < 3) m_cnt[i]++;
        else if (!tk && m_cnt[i] > 0) m_cnt[i]--;
        m_ghr = mis ? {h[10:0], tk} : {m_ghr[10:0], tk};
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
        chk(flush == mis, "R10", "flush after update", 32'(flush), 32'(mis));
        if (mis) begin
            chk(redirect_pc == (tk ? tgt : pc + 32'd4), "R10", "redirect_pc",
                redirect_pc, tk ? tgt : pc + 32'd4);
            @(negedge clk);
            chk(flush == 1'b0, "R10", "flush one cycle", 32'(flush), 32'd0);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) m_cnt[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pred_valid == 1'b0, "R1", "pred_valid reset", 32'(pred_valid), 32'd0);
        chk(flush == 1'b0, "R1", "flush reset", 32'(flush), 32'd0);

        // R1 R4: cold tables, weakly not taken
        fetch(32'h1000, 0, 0, 2'd0, 0, "R4");

        // R6 R3: allocation and hit
        update(32'h1004, 1, 32'h2000, 0, m_ghr);
        fetch(32'h1000, 0, 0, 2'd1, 32'h2000, "R3");
        fetch(32'h1004, 0, 0, 2'd1, 32'h2000, "R3");

        // R6: fill both ways, then LRU eviction
        update(32'h1804, 1, 32'h3000, 0, m_ghr);
        update(32'h2804, 1, 32'h4000, 0, m_ghr);
        fetch(32'h1000, 0, 0, 2'd0, 0, "R6");
        fetch(32'h1800, 0, 0, 2'd1, 32'h3000, "R6");
        fetch(32'h2800, 0, 0, 2'd1, 32'h4000, "R6");
        update(32'h1004, 1, 32'h2000, 0, m_ghr);
        fetch(32'h1800, 0, 0, 2'd0, 0, "R6");
        fetch(32'h2800, 0, 0, 2'd1, 32'h4000, "R6");
        fetch(32'h1000, 0, 0, 2'd1, 32'h2000, "R6");

        // R7: not-taken hit drops the entry
        update(32'h2804, 0, 0, 0, m_ghr);
        fetch(32'h2800, 0, 0, 2'd0, 0, "R7");

        // R5 R9: train one counter, then restore history by misprediction
        for (int k = 0; k < 3; k++) update(32'h5000, 1, 32'h9000, 0, 12'h0A4);
        update(32'h5000, 0, 0, 0, 12'h3C3);
        update(32'h6000, 0, 0, 1, 12'h052);
        fetch(32'h5000, 0, 0, 2'd0, 0, "R9");
        update(32'h5000, 0, 0, 0, 12'h0A4);
        update(32'h6000, 0, 0, 1, 12'h052);
        fetch(32'h5000, 0, 0, 2'd0, 0, "R5");
        update(32'h5000, 0, 0, 0, 12'h0A4);
        update(32'h6000, 0, 0, 1, 12'h052);
        fetch(32'h5000, 0, 0, 2'd0, 0, "R5");

        // R10: taken misprediction redirects to target and allocates
        update(32'h7004, 1, 32'h7700, 1, m_ghr);
        fetch(32'h7000, 0, 0, 2'd1, 32'h7700, "R8");

        // R11 R12 R13: return stack
        fetch(32'h0100, 1, 0, 2'd0, 0, "R12");
        fetch(32'h0200, 0, 1, 2'd2, 32'h0104, "R11");
        fetch(32'h0300, 0, 1, 2'd2, 32'h0104, "R13");
        fetch(32'h7000, 0, 1, 2'd2, 32'h0104, "R11");
        for (int k = 0; k < 9; k++) fetch(32'h0400 + 32'(k) * 32'h10, 1, 0, 2'd0, 0, "R12");
        for (int k = 8; k >= 1; k--) fetch(32'h0900, 0, 1, 2'd2, 32'h0404 + 32'(k) * 32'h10, "R12");
        fetch(32'h0900, 0, 1, 2'd2, 32'h0414, "R13");

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule